// File: doc/BRIEF.md
# Two-Line Interrupt Controller with Lowest-Source Vector

This block collects level-sensitive interrupt requests from a parameterised number of sources. The sources are grouped into banks of equal width. It drives two request lines toward a processor: a normal line and a fast line. Software reaches it through a simple word-wide register bus with separate read and write strobes, a byte address and write data.

Each source that is high and not blocked raises the normal line. A per-source steering bit also routes that source to the fast line. A vector register tells the handler which source to serve. It holds the index of the lowest-numbered active source multiplied by four, so it can be used directly as a byte offset into a table of word-sized entries.

The block also keeps a small amount of plain storage for software: a table base word, a protect word, a non-maskable control word and per-bank enable words. None of this storage changes how the request lines behave.

Top module: `irqc_top`

## Requirements
- R1: After reset every readable register returns 0, and both request lines are low.
- R2: Source n is reported in bit n%32 of the status word at byte offset 0x10+4*(n/32). That bit follows the level of the source: high sets it and low clears it.
- R3: The normal line is high exactly when some source is high while its block bit is 0. A block bit of 1 suppresses its source. The block words are at 0x50+4*bank.
- R4: The fast line is high exactly when some source is high, unblocked, and has its steering bit set to 1. The steering words are at 0x30+4*bank.
- R5: The word at offset 0x00 reads (index of the lowest-numbered unblocked high source) * 4. It reads 0 when no source is active.
- R6: Writes to the status words at 0x10+4*bank change nothing.
- R7: The fast-status words at 0x20+4*bank read 0 after reset. A write clears every bit that is written as 1 and leaves the bits written as 0 unchanged.
- R8: A write to the base word at 0x04 stores the written value with bits [1:0] forced to 0.
- R9: The protect word (0x08), the non-maskable control word (0x0C) and the enable words (0x40+4*bank) read back what was last written. The enable bits do not affect either request line.
- R10: Reads from unmapped offsets return 0, and writes to them are ignored. Examples are 0x1C, 0x100 and any offset that is not word-aligned. Writes to offset 0x00 are also ignored.
- R11: A change on a source or a register write shows on the request lines and the vector at the first rising clock edge that samples it. Read data appears one clock after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | NUM_BANKS*BANK_W | Level-sensitive interrupt sources |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address within the register window |
| bus_wdata | input | BANK_W | Write data |
| bus_rdata | output | BANK_W | Read data, valid one clock after bus_rd |
| cpu_irq | output | 1 | Registered normal request line |
| cpu_fiq | output | 1 | Registered fast request line |

## Verification
The bench builds the block with its defaults: three banks of 32 sources and a 10-bit address. This puts the last source (95, vector 380) in reach, along with the unmapped gap at 0x1C that lies just past the third status word. The bench runs several sources at once in different banks. This shows that the vector follows the lowest unblocked source across bank boundaries, and that blocking that source moves the vector on to the next one.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [2:0] {
    GRP_NONE,
    GRP_SCALAR,
    GRP_PEND,
    GRP_FPEND,
    GRP_SEL,
    GRP_EN,
    GRP_MASK
  } grp_e;

  localparam logic [1:0] SC_VECTOR = 2'd0;
  localparam logic [1:0] SC_BASE   = 2'd1;
  localparam logic [1:0] SC_PROT   = 2'd2;
  localparam logic [1:0] SC_NMI    = 2'd3;
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
  import irqc_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int NUM_BANKS = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output grp_e              grp,
  output logic [1:0]        idx
);
  logic       upper_zero;
  logic [2:0] page;

  assign upper_zero = (addr[ADDR_W-1:7] == '0);
  assign page       = addr[6:4];
  assign idx        = addr[3:2];

  always_comb begin
    grp = GRP_NONE;
    if (upper_zero && addr[1:0] == 2'b00) begin
      if (page == 3'd0) begin
        grp = GRP_SCALAR;
      end else if (32'(idx) < NUM_BANKS) begin
        case (page)
          3'd1:    grp = GRP_PEND;
          3'd2:    grp = GRP_FPEND;
          3'd3:    grp = GRP_SEL;
          3'd4:    grp = GRP_EN;
          3'd5:    grp = GRP_MASK;
          default: grp = GRP_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank #(
  parameter int BANK_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BANK_W-1:0] src,
  input  logic [BANK_W-1:0] wdata,
  input  logic              wr_fpend,
  input  logic              wr_sel,
  input  logic              wr_en,
  input  logic              wr_mask,
  output logic [BANK_W-1:0] pend_q,
  output logic [BANK_W-1:0] fpend_q,
  output logic [BANK_W-1:0] sel_q,
  output logic [BANK_W-1:0] en_q,
  output logic [BANK_W-1:0] mask_q,
  output logic [BANK_W-1:0] act_nxt,
  output logic [BANK_W-1:0] fact_nxt
);
  logic [BANK_W-1:0] mask_nxt;
  logic [BANK_W-1:0] sel_nxt;

  assign mask_nxt = wr_mask ? wdata : mask_q;
  assign sel_nxt  = wr_sel  ? wdata : sel_q;
  assign act_nxt  = src & ~mask_nxt;
  assign fact_nxt = act_nxt & sel_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= '0;
      fpend_q <= '0;
      sel_q   <= '0;
      en_q    <= '0;
      mask_q  <= '0;
    end else begin
      pend_q <= src;
      mask_q <= mask_nxt;
      sel_q  <= sel_nxt;
      if (wr_en)    en_q    <= wdata;
      if (wr_fpend) fpend_q <= fpend_q & ~wdata;
    end
  end

  // R2
  pend_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> pend_q == $past(src));

  // R7
  fpend_clr_chk: assert property (@(posedge clk) disable iff (rst)
    wr_fpend |=> (fpend_q & $past(wdata)) == '0);
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int N     = 96,
  parameter int VEC_W = 32
) (
  input  logic [N-1:0]     act,
  output logic             found,
  output logic [VEC_W-1:0] vec
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [IDX_W-1:0] idx;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (act[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

  assign vec = found ? (VEC_W'(idx) << 2) : '0;
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int BANK_W    = 32,
  parameter int ADDR_W    = 10
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_BANKS*BANK_W-1:0]   irq_src,
  input  logic                          bus_rd,
  input  logic                          bus_wr,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [BANK_W-1:0]             bus_wdata,
  output logic [BANK_W-1:0]             bus_rdata,
  output logic                          cpu_irq,
  output logic                          cpu_fiq
);
  localparam int NSRC = NUM_BANKS * BANK_W;

  grp_e       grp;
  logic [1:0] idx;

  logic [BANK_W-1:0] pend_b  [NUM_BANKS];
  logic [BANK_W-1:0] fpend_b [NUM_BANKS];
  logic [BANK_W-1:0] sel_b   [NUM_BANKS];
  logic [BANK_W-1:0] en_b    [NUM_BANKS];
  logic [BANK_W-1:0] mask_b  [NUM_BANKS];
  logic [NSRC-1:0]   act_all;
  logic [NSRC-1:0]   fact_all;
  logic [NSRC-1:0]   act_now;

  logic [BANK_W-1:0] vec_q, base_q, prot_q, nmi_q, rd_val;
  logic [BANK_W-1:0] vec_nxt;
  logic              vec_found;

  irqc_decode #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) u_dec (
    .addr (bus_addr),
    .grp  (grp),
    .idx  (idx)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = bus_wr && (32'(idx) == b);

    irqc_bank #(.BANK_W(BANK_W)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .src      (irq_src[b*BANK_W +: BANK_W]),
      .wdata    (bus_wdata),
      .wr_fpend (hit && grp == GRP_FPEND),
      .wr_sel   (hit && grp == GRP_SEL),
      .wr_en    (hit && grp == GRP_EN),
      .wr_mask  (hit && grp == GRP_MASK),
      .pend_q   (pend_b[b]),
      .fpend_q  (fpend_b[b]),
      .sel_q    (sel_b[b]),
      .en_q     (en_b[b]),
      .mask_q   (mask_b[b]),
      .act_nxt  (act_all[b*BANK_W +: BANK_W]),
      .fact_nxt (fact_all[b*BANK_W +: BANK_W])
    );

    assign act_now[b*BANK_W +: BANK_W] = pend_b[b] & ~mask_b[b];
  end

  irqc_prio #(.N(NSRC), .VEC_W(BANK_W)) u_prio (
    .act   (act_all),
    .found (vec_found),
    .vec   (vec_nxt)
  );

  always_comb begin
    rd_val = '0;
    case (grp)
      GRP_SCALAR: begin
        case (idx)
          SC_VECTOR: rd_val = vec_q;
          SC_BASE:   rd_val = base_q;
          SC_PROT:   rd_val = prot_q;
          default:   rd_val = nmi_q;
        endcase
      end
      GRP_PEND, GRP_FPEND, GRP_SEL, GRP_EN, GRP_MASK: begin
        for (int b = 0; b < NUM_BANKS; b++) begin
          if (32'(idx) == b) begin
            case (grp)
              GRP_PEND:  rd_val = pend_b[b];
              GRP_FPEND: rd_val = fpend_b[b];
              GRP_SEL:   rd_val = sel_b[b];
              GRP_EN:    rd_val = en_b[b];
              default:   rd_val = mask_b[b];
            endcase
          end
        end
      end
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_irq   <= 1'b0;
      cpu_fiq   <= 1'b0;
      vec_q     <= '0;
      base_q    <= '0;
      prot_q    <= '0;
      nmi_q     <= '0;
      bus_rdata <= '0;
    end else begin
      cpu_irq <= vec_found;
      cpu_fiq <= |fact_all;
      vec_q   <= vec_nxt;
      if (bus_rd) bus_rdata <= rd_val;
      if (bus_wr && grp == GRP_SCALAR) begin
        case (idx)
          SC_BASE: base_q <= {bus_wdata[BANK_W-1:2], 2'b00};
          SC_PROT: prot_q <= bus_wdata;
          SC_NMI:  nmi_q  <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  // R3
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_irq == (|act_now));

  // R4
  fiq_sub_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_fiq |-> cpu_irq);

  // R5
  vec_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !cpu_irq |-> vec_q == '0);

  // R8
  base_align_chk: assert property (@(posedge clk) disable iff (rst)
    base_q[1:0] == 2'b00);
endmodule

// File: tb/test_irqc_top.sv
module test_irqc_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 3;
  localparam int BW = 32;
  localparam int NS = NB * BW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] irq_src = '0;
  logic          bus_rd = 1'b0;
  logic          bus_wr = 1'b0;
  logic [9:0]    bus_addr = '0;
  logic [BW-1:0] bus_wdata = '0;
  logic [BW-1:0] bus_rdata;
  logic          cpu_irq, cpu_fiq;

  int checks = 0;
  int failures = 0;
  logic [NS-1:0] mask_m = '0;
  logic [NS-1:0] sel_m = '0;

  irqc_top #(.NUM_BANKS(NB), .BANK_W(BW), .ADDR_W(10)) i_irqc_top (
    .clk(clk), .rst(rst), .irq_src(irq_src), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_irq(cpu_irq), .cpu_fiq(cpu_fiq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [9:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    if (a >= 10'h50 && a <= 10'h58 && a[1:0] == 0) mask_m[(a - 10'h50) / 4 * BW +: BW] = d;
    if (a >= 10'h30 && a <= 10'h38 && a[1:0] == 0) sel_m[(a - 10'h30) / 4 * BW +: BW] = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic set_src(int n, logic v);
    @(negedge clk);
    irq_src[n] = v;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] exp_vec();
    for (int i = 0; i < NS; i++)
      if (irq_src[i] && !mask_m[i]) return 32'(i * 4);
    return 32'd0;
  endfunction

  function automatic logic exp_irq();
    return |(irq_src & ~mask_m);
  endfunction

  function automatic logic exp_fiq();
    return |(irq_src & ~mask_m & sel_m);
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", 32'(cpu_irq), 0);
    check("R1 fiq", 32'(cpu_fiq), 0);
    for (int a = 0; a < 'h60; a += 4) begin
      rd(10'(a), d);
      check("R1 reg", d, 0);
    end
  endtask

  task automatic t_pending();
    logic [31:0] d;
    set_src(0, 1); set_src(33, 1); set_src(95, 1);
    rd(10'h10, d); check("R2 bank0", d, 32'h0000_0001);
    rd(10'h14, d); check("R2 bank1", d, 32'h0000_0002);
    rd(10'h18, d); check("R2 bank2", d, 32'h8000_0000);
    set_src(33, 0);
    rd(10'h14, d); check("R2 clear", d, 0);
    set_src(0, 0); set_src(95, 0);
    check("R2 idle irq", 32'(cpu_irq), 0);
  endtask

  task automatic t_timing();
    logic [31:0] d;
    @(negedge clk);
    irq_src[40] = 1'b1;
    #1;
    check("R11 before edge", 32'(cpu_irq), 0);
    @(posedge clk);
    @(negedge clk);
    check("R11 after edge irq", 32'(cpu_irq), 1);
    rd(10'h00, d);
    check("R11 vector", d, 32'd160);
  endtask

  task automatic t_mask();
    wr(10'h54, 32'h0000_0100);
    check("R3 masked irq", 32'(cpu_irq), 32'(exp_irq()));
    check("R3 masked low", 32'(cpu_irq), 0);
    wr(10'h54, 0);
    check("R3 unmasked irq", 32'(cpu_irq), 1);
  endtask

  task automatic t_fiq();
    check("R4 no select", 32'(cpu_fiq), 0);
    wr(10'h34, 32'h0000_0100);
    check("R4 selected fiq", 32'(cpu_fiq), 32'(exp_fiq()));
    check("R4 fiq high", 32'(cpu_fiq), 1);
    wr(10'h54, 32'h0000_0100);
    check("R4 masked fiq", 32'(cpu_fiq), 0);
    wr(10'h54, 0);
    wr(10'h34, 0);
    check("R4 deselect", 32'(cpu_fiq), 0);
    set_src(40, 0);
  endtask

  task automatic t_vector();
    logic [31:0] d;
    set_src(70, 1); set_src(95, 1);
    rd(10'h00, d); check("R5 vec 70", d, exp_vec());
    set_src(5, 1);
    rd(10'h00, d); check("R5 vec 5", d, 32'd20);
    wr(10'h50, 32'h0000_0020);
    rd(10'h00, d); check("R5 vec masked", d, 32'd280);
    wr(10'h58, 32'h8000_0000);
    wr(10'h58, 0);
    set_src(70, 0);
    rd(10'h00, d); check("R5 vec 95", d, 32'd380);
    set_src(95, 0);
    rd(10'h00, d); check("R5 only masked", d, 0);
    wr(10'h50, 0);
    rd(10'h00, d); check("R5 vec 5 again", d, 32'd20);
    set_src(5, 0);
    rd(10'h00, d); check("R5 none", d, 0);
  endtask

  task automatic t_pend_write();
    logic [31:0] d;
    wr(10'h14, 32'hFFFF_FFFF);
    rd(10'h14, d); check("R6 pend write", d, 0);
    check("R6 irq", 32'(cpu_irq), 0);
  endtask

  task automatic t_fpend();
    logic [31:0] d;
    wr(10'h20, 32'hFFFF_FFFF);
    rd(10'h20, d); check("R7 fpend bank0", d, 0);
    wr(10'h28, 32'h0000_0000);
    rd(10'h28, d); check("R7 fpend bank2", d, 0);
  endtask

  task automatic t_base();
    logic [31:0] d;
    wr(10'h04, 32'hDEAD_BEEF);
    rd(10'h04, d); check("R8 base", d, 32'hDEAD_BEEC);
  endtask

  task automatic t_plain();
    logic [31:0] d;
    wr(10'h08, 32'h1234_5678); rd(10'h08, d); check("R9 protect", d, 32'h1234_5678);
    wr(10'h0C, 32'hA5A5_0003); rd(10'h0C, d); check("R9 nmi", d, 32'hA5A5_0003);
    wr(10'h44, 32'hCAFE_0001); rd(10'h44, d); check("R9 enable", d, 32'hCAFE_0001);
    rd(10'h40, d); check("R9 enable other", d, 0);
    set_src(10, 1);
    check("R9 enable no gate", 32'(cpu_irq), 1);
    set_src(10, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    set_src(3, 1);
    wr(10'h1C, 32'hFFFF_FFFF); rd(10'h1C, d); check("R10 gap", d, 0);
    wr(10'h100, 32'hFFFF_FFFF); rd(10'h100, d); check("R10 high", d, 0);
    wr(10'h45, 32'hFFFF_FFFF); rd(10'h44, d); check("R10 unaligned", d, 32'hCAFE_0001);
    rd(10'h5C, d); check("R10 past mask", d, 0);
    wr(10'h00, 32'h0000_0100); rd(10'h00, d); check("R10 vector ro", d, 32'd12);
    rd(10'h50, d); check("R10 mask untouched", d, 0);
    set_src(3, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_pending();
    t_timing();
    t_mask();
    t_fiq();
    t_vector();
    t_pend_write();
    t_fpend();
    t_base();
    t_plain();
    t_unmapped();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule